// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers low-speed USB packets from the two data lines, sampled by a clock that runs at about eight times the 1.5 Mbit/s bit rate. Each sample is resolved into J (D- high, D+ low), K (D+ high, D- low) or SE0 (both low). A free-running bit-phase counter snaps back to zero whenever the line state changes, so the receiver samples near the middle of each bit even when the sender's rate drifts. Once it has locked onto a SYNC pattern, it undoes the NRZI coding, drops stuffed bits and packs the decoded bits into bytes, least significant bit first.

The first byte after SYNC is the packet identifier. If it is well formed, the receiver reports it; if it is malformed, the whole packet is discarded. Every later byte is presented as data, and for a data packet this includes the two CRC bytes. A running CRC16 is checked when the end-of-packet marker arrives. A long stretch of SE0 is reported as a bus reset, on an output of its own. A downstream protocol engine consumes the single-cycle strobes.

Top module: `usb_ls_rx`

## Requirements
- R1: The two line inputs are passed through a two-stage synchronizer. A sample is J when dm=1 and dp=0, K when dp=1 and dm=0, and SE0 when both are 0. All outputs are 0 after reset.
- R2: Starting from idle J, the line sequence K J K J K J K K is recognised as SYNC, and its final K is the NRZI reference for the first packet bit. A decoded bit is 1 when the line keeps its level from the previous bit and 0 when the level changes.
- R3: The bit phase restarts at every change of line state, and each bit is sampled at its fifth sample (index SPB/2). Packets whose bits last 7 or 9 samples, with at most three equal bits in a row, still decode correctly.
- R4: Ones are counted from the first bit after SYNC. After six decoded ones in a row, the next bit is expected to be a stuffed 0 and is removed from the data.
- R5: If the bit after six ones is a 1, err_stuff pulses and nothing more is reported for that packet.
- R6: pid_valid pulses, with pid set to the low nibble of the first byte, only if the high nibble of that byte is the bitwise complement of the low nibble. Otherwise err_pid pulses and the packet is dropped without any further output or end-of-packet pulse.
- R7: Every byte after the PID is assembled LSB first and presented with a single data_valid pulse. For a data packet this includes both CRC bytes.
- R8: The first bit-centre sample of SE0 inside a packet pulses eop. For packets whose PID low bits are 2'b11 (data PIDs), err_crc pulses together with eop when the CRC16 register (x^16+x^15+x^2+1, preset to all ones, run over every bit after the PID) does not hold 16'h800D. Handshake packets never raise err_crc.
- R9: After an end of packet, once J is seen again, the receiver hunts for the next SYNC, so packets separated by a few idle bits are all received.
- R10: bus_reset rises once RESET_SAMPLES consecutive synchronised SE0 samples have been seen. It falls on the first sample that is not SE0. A normal two-bit end of packet never raises it.
- R11: At most one of pid_valid, data_valid, eop, err_stuff and err_pid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, about SPB samples per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp | input | 1 | D+ line level |
| dm | input | 1 | D- line level |
| pid_valid | output | 1 | One-cycle strobe: a valid packet identifier was received |
| pid | output | 4 | Low nibble of the last valid packet identifier |
| data_valid | output | 1 | One-cycle strobe: a byte after the PID was received |
| data | output | 8 | Last received byte |
| eop | output | 1 | One-cycle strobe: end of packet |
| err_crc | output | 1 | High together with eop when a data packet fails its CRC |
| err_stuff | output | 1 | One-cycle strobe: bit-stuffing violation |
| err_pid | output | 1 | One-cycle strobe: malformed packet identifier |
| bus_reset | output | 1 | High while a long SE0 is present |

## Verification
The hardest condition to reach is a bit-stuffing violation. A correct transmitter never sends seven ones in a row, so the bench's encoder has a switch that turns off stuff insertion and then sends a payload of 0xFF right after a DATA0 identifier. A second hard case is drift in the bit clock: handshake packets are sent with bits 7 and 9 samples long, so they decode correctly only if the phase re-centres on each edge. A wrong CRC is produced by flipping the last transmitted CRC bit.

// File: rtl/usb_ls_rx.sv
module usb_ls_rx #(
  parameter int SPB           = 8,
  parameter int RESET_SAMPLES = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp,
  input  logic       dm,
  output logic       pid_valid,
  output logic [3:0] pid,
  output logic       data_valid,
  output logic [7:0] data,
  output logic       eop,
  output logic       err_crc,
  output logic       err_stuff,
  output logic       err_pid,
  output logic       bus_reset
);

  localparam int PW   = (SPB > 2) ? $clog2(SPB) : 1;
  localparam int RW   = $clog2(RESET_SAMPLES + 1);
  localparam int HALF = SPB / 2;
  localparam logic [1:0] LS_SE0 = 2'd0, LS_J = 2'd1, LS_K = 2'd2;
  localparam logic [15:0] CRC_RESIDUE = 16'h800D;

  typedef enum logic [2:0] {HUNT, BODY, DROP, WAITJ} st_t;

  logic [1:0]    s_dp, s_dm, ls, ls_q, prev_lvl;
  logic [PW-1:0] phase, cur;
  logic          strobe, is_jk, d_bit;
  logic [7:0]    hsr, byte_sr, byte_nx, hunt_nx;
  logic [2:0]    ones, bitcnt;
  logic          have_pid, is_data;
  logic [15:0]   crc, crc_nx;
  logic [RW-1:0] se0_cnt;
  st_t           st;

  assign ls      = {s_dp[1], s_dm[1]};
  assign is_jk   = (ls == LS_J) || (ls == LS_K);
  assign cur     = (ls != ls_q) ? '0 : ((phase == PW'(SPB - 1)) ? '0 : phase + 1'b1);
  assign strobe  = (cur == PW'(HALF));
  assign d_bit   = (ls == prev_lvl);
  assign byte_nx = {d_bit, byte_sr[7:1]};
  assign hunt_nx = {d_bit, hsr[7:1]};
  assign crc_nx  = {crc[14:0], 1'b0} ^ ((d_bit ^ crc[15]) ? 16'h8005 : 16'h0000);
  assign bus_reset = (se0_cnt == RW'(RESET_SAMPLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_dp    <= 2'b00;
      s_dm    <= 2'b11;
      ls_q    <= LS_J;
      phase   <= '0;
      se0_cnt <= '0;
    end else begin
      s_dp    <= {s_dp[0], dp};
      s_dm    <= {s_dm[0], dm};
      ls_q    <= ls;
      phase   <= cur;
      if (ls != LS_SE0)
        se0_cnt <= '0;
      else if (!bus_reset)
        se0_cnt <= se0_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= HUNT;
      prev_lvl   <= LS_J;
      hsr        <= 8'hFF;
      byte_sr    <= '0;
      ones       <= '0;
      bitcnt     <= '0;
      have_pid   <= 1'b0;
      is_data    <= 1'b0;
      crc        <= 16'hFFFF;
      pid_valid  <= 1'b0;
      pid        <= '0;
      data_valid <= 1'b0;
      data       <= '0;
      eop        <= 1'b0;
      err_crc    <= 1'b0;
      err_stuff  <= 1'b0;
      err_pid    <= 1'b0;
    end else begin
      pid_valid  <= 1'b0;
      data_valid <= 1'b0;
      eop        <= 1'b0;
      err_crc    <= 1'b0;
      err_stuff  <= 1'b0;
      err_pid    <= 1'b0;
      case (st)
        HUNT: if (strobe) begin
          if (is_jk) begin
            prev_lvl <= ls;
            hsr      <= hunt_nx;
            if (hunt_nx == 8'h80) begin
              st       <= BODY;
              ones     <= '0;
              bitcnt   <= '0;
              have_pid <= 1'b0;
              is_data  <= 1'b0;
              crc      <= 16'hFFFF;
            end
          end else begin
            hsr      <= 8'hFF;
            prev_lvl <= LS_J;
          end
        end
        BODY: if (strobe) begin
          if (ls == LS_SE0) begin
            eop     <= 1'b1;
            err_crc <= have_pid && is_data && (crc != CRC_RESIDUE);
            st      <= WAITJ;
          end else if (!is_jk) begin
            st <= DROP;
          end else begin
            prev_lvl <= ls;
            if (ones == 3'd6) begin
              ones <= '0;
              if (d_bit) begin
                err_stuff <= 1'b1;
                st        <= DROP;
              end
            end else begin
              ones    <= d_bit ? ones + 1'b1 : '0;
              byte_sr <= byte_nx;
              bitcnt  <= bitcnt + 1'b1;
              if (have_pid && is_data) crc <= crc_nx;
              if (bitcnt == 3'd7) begin
                if (have_pid) begin
                  data_valid <= 1'b1;
                  data       <= byte_nx;
                end else if (byte_nx[7:4] == ~byte_nx[3:0]) begin
                  pid_valid <= 1'b1;
                  pid       <= byte_nx[3:0];
                  have_pid  <= 1'b1;
                  is_data   <= (byte_nx[1:0] == 2'b11);
                end else begin
                  err_pid <= 1'b1;
                  st      <= DROP;
                end
              end
            end
          end
        end
        DROP: if (ls == LS_SE0) st <= WAITJ;
        WAITJ: if (ls == LS_J) begin
          st       <= HUNT;
          hsr      <= 8'hFF;
          prev_lvl <= LS_J;
        end
        default: st <= HUNT;
      endcase
    end
  end

  p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pid_valid, data_valid, eop, err_stuff, err_pid}));

  p_crc_with_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |-> eop);

  p_eop_from_se0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> $past(ls) == LS_SE0);

  p_reset_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ls != LS_SE0) |=> !bus_reset);

  p_stuff_on_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_stuff |-> $past(is_jk));

endmodule

// File: tb/tb_usb_ls_rx.sv
module tb_usb_ls_rx;
  localparam int SPB = 8;
  localparam int RS  = 80;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
  logic pid_valid, data_valid, eop, err_crc, err_stuff, err_pid, bus_reset;
  logic [3:0] pid;
  logic [7:0] data;

  int tests = 0, fails = 0, bitlen = SPB;
  logic [11:0] exp_q[$];
  logic [7:0]  pay[$];
  logic        br_seen = 1'b0;
  string       tag = "R1";

  always #10 clk = ~clk;

  usb_ls_rx #(.SPB(SPB), .RESET_SAMPLES(RS)) dut (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm),
    .pid_valid(pid_valid), .pid(pid), .data_valid(data_valid), .data(data),
    .eop(eop), .err_crc(err_crc), .err_stuff(err_stuff), .err_pid(err_pid),
    .bus_reset(bus_reset));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
    tests++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, expv);
    end
  endtask

  // item: {kind[2:0], flag, value[7:0]}; kinds 1 pid, 2 data, 3 eop, 4 stuff err, 5 pid err
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_reset) br_seen = 1'b1;
      if (pid_valid || data_valid || eop || err_stuff || err_pid) begin
        logic [11:0] got;
        if (pid_valid)       got = {3'd1, 1'b0, 4'h0, pid};
        else if (data_valid) got = {3'd2, 1'b0, data};
        else if (eop)        got = {3'd3, err_crc, 8'h00};
        else if (err_stuff)  got = {3'd4, 1'b0, 8'h00};
        else                 got = {3'd5, 1'b0, 8'h00};
        if (exp_q.size() == 0) check({tag, " unexpected"}, {20'h0, got}, 32'h0);
        else check(tag, {20'h0, got}, {20'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic drive(input logic [1:0] s, input int n);
    dp = s[1];
    dm = s[0];
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] pidb, input bit crc_flip, input bit no_stuff, input bit auto_exp);
    bit bits[$];
    logic [15:0] crc = 16'hFFFF;
    logic [7:0] c1, c2;
    logic [1:0] lvl = K;
    int ones = 0;
    bit is_data = (pidb[1:0] == 2'b11);
    bit pid_ok = (pidb[7:4] == ~pidb[3:0]);
    for (int i = 0; i < 8; i++) bits.push_back(pidb[i]);
    foreach (pay[k]) for (int i = 0; i < 8; i++) begin
      bits.push_back(pay[k][i]);
      crc = {crc[14:0], 1'b0} ^ ((pay[k][i] ^ crc[15]) ? 16'h8005 : 16'h0);
    end
    if (is_data) begin
      for (int i = 0; i < 16; i++) begin
        bit b = ~crc[15-i];
        if (i == 15 && crc_flip) b = ~b;
        bits.push_back(b);
        if (i < 8) c1[i] = b; else c2[i-8] = b;
      end
    end
    if (auto_exp) begin
      if (!pid_ok) exp_q.push_back({3'd5, 1'b0, 8'h00});
      else begin
        exp_q.push_back({3'd1, 1'b0, 4'h0, pidb[3:0]});
        foreach (pay[k]) exp_q.push_back({3'd2, 1'b0, pay[k]});
        if (is_data) begin
          exp_q.push_back({3'd2, 1'b0, c1});
          exp_q.push_back({3'd2, 1'b0, c2});
        end
        exp_q.push_back({3'd3, crc_flip, 8'h00});
      end
    end
    drive(J, 3 * bitlen);
    drive(K, bitlen); drive(J, bitlen); drive(K, bitlen); drive(J, bitlen);
    drive(K, bitlen); drive(J, bitlen); drive(K, bitlen); drive(K, bitlen);
    foreach (bits[i]) begin
      if (!no_stuff && ones == 6) begin
        lvl = (lvl == J) ? K : J;
        drive(lvl, bitlen);
        ones = 0;
      end
      if (!bits[i]) lvl = (lvl == J) ? K : J;
      ones = bits[i] ? ones + 1 : 0;
      drive(lvl, bitlen);
    end
    drive(SE0, 2 * bitlen);
    drive(J, 6 * bitlen);
  endtask

  task automatic drained(input string req);
    check({req, " queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs",
          {pid_valid, data_valid, eop, err_crc, err_stuff, err_pid, bus_reset}, 0);

    tag = "R2"; pay = {};               // ACK 0xD2
    send(8'hD2, 0, 0, 1); drained("R2");
    tag = "R9"; send(8'h5A, 0, 0, 1);   // NAK right after
    send(8'hD2, 0, 0, 1); drained("R9");

    tag = "R7"; pay = {8'h01, 8'h80, 8'h3C};  // DATA0 with good CRC
    send(8'hC3, 0, 0, 1); drained("R7");
    tag = "R8"; pay = {8'h55, 8'hAA};         // DATA1, bad CRC
    send(8'h4B, 1, 0, 1); drained("R8");
    tag = "R8"; pay = {8'h00};                // DATA0, good CRC
    send(8'hC3, 0, 0, 1); drained("R8");

    tag = "R4"; pay = {8'hFF, 8'hFF, 8'h7E};  // long runs of ones
    send(8'hC3, 0, 0, 1); drained("R4");

    tag = "R5"; pay = {8'hFF};                // no stuffing inserted
    exp_q.push_back({3'd1, 1'b0, 4'h0, 4'h3});
    exp_q.push_back({3'd4, 1'b0, 8'h00});
    send(8'hC3, 0, 1, 0); drained("R5");
    pay = {}; send(8'hD2, 0, 0, 1); drained("R5 recovery");

    tag = "R6"; pay = {8'h12};                // high nibble not complement
    send(8'hC2, 0, 0, 1); drained("R6");
    pay = {}; send(8'h5A, 0, 0, 1); drained("R6 recovery");

    tag = "R3"; pay = {};
    bitlen = 9; send(8'hD2, 0, 0, 1); send(8'h5A, 0, 0, 1); drained("R3 slow");
    bitlen = 7; send(8'hD2, 0, 0, 1); send(8'h5A, 0, 0, 1); drained("R3 fast");
    bitlen = SPB;

    check("R10 no reset from normal EOP", br_seen, 0);
    tag = "R10";
    drive(SE0, RS + 1);
    check("R10 below threshold", bus_reset, 0);
    drive(SE0, 1);
    check("R10 at threshold", bus_reset, 1);
    drive(SE0, 20);
    check("R10 held", bus_reset, 1);
    drive(J, 4);
    check("R10 released", bus_reset, 0);
    drive(J, 40);
    check("R11 no stray events after reset", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule